// File: doc/BRIEF.md
# Oblivious-RAM Path Re-encryption Selector

This block sits in the write-back stage of a tree-based oblivious RAM controller. After the read phase has fetched every bucket on the path from the root to one leaf, the controller knows which slots now hold new or modified blocks. It hands this per-slot flag vector to the selector. The selector returns a per-slot mask of the slots that must be re-encrypted and written back, and a per-slot strobe that tells the two-level counter logic which slot counters to advance.

The selector does not re-encrypt every slot on the path. It first finds the largest number of modified slots in any one bucket. That number becomes the target for the whole path. Every modified slot is kept in the mask. Each bucket below the target is then padded with distinct unmodified slots, chosen at random, until it reaches the target. All other slots keep their old ciphertext. Because every bucket shows the same number of writes, the write pattern reveals nothing about where the modified blocks sit.

The random choice comes from an internal LFSR, which can be seeded through a load port. Each request is a start pulse carrying the flag vector. The block raises busy, works for a few cycles, and then pulses done with the mask, the target and the counter strobes.

Top module: `ore_path_reenc_sel`

## Requirements
- R1: At done, `target` equals the largest count of set `mod_flags` bits in any single bucket. Bucket b occupies bits b*SLOTS to b*SLOTS+SLOTS-1, and there are DEPTH+1 buckets.
- R2: At done, every slot whose `mod_flags` bit was set at acceptance is also set in `reenc_mask`.
- R3: At done, every bucket slice of `reenc_mask` has exactly `target` bits set. Padding slots are distinct and are drawn only from unmodified slots.
- R4: When no flag is set, done reports `target` = 0 and `reenc_mask` all zeros.
- R5: `ctr_strobe` equals `reenc_mask` in the done cycle and is all zeros in every other cycle.
- R6: `busy` is high from the cycle after a start is accepted up to and including the done cycle. `done` is high for one cycle only. That cycle begins P+2 rising edges after the accepting edge, where P is `target` minus the smallest per-bucket modified count.
- R7: A `start` raised while `busy` is high is ignored. The running access completes with its own flags, and no extra done follows.
- R8: Loading the same seed through `seed_load`/`seed_value` and then sending the same flag vector gives the same `reenc_mask` both times.
- R9: After reset, `busy`, `done`, `reenc_mask`, `target` and `ctr_strobe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load `seed_value` into the LFSR; a zero seed is replaced by a nonzero constant |
| seed_value | input | LFSR_W | Seed for the padding LFSR |
| start | input | 1 | Request; accepted when not busy |
| mod_flags | input | (DEPTH+1)*SLOTS | Per-slot new/modified flags, captured on acceptance |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle result-valid pulse |
| reenc_mask | output | (DEPTH+1)*SLOTS | Slots to re-encrypt and write back |
| target | output | $clog2(SLOTS+1) | Path-wide re-encryption count per bucket |
| ctr_strobe | output | (DEPTH+1)*SLOTS | Per-slot counter-update strobe, valid in the done cycle |

## Verification
The bench drives a set of flag vectors, each chosen to separate one behaviour:
- An empty path checks the zero-target case.
- A single set bit forces padding in every other bucket.
- One full bucket forces the whole path to be written.
- Equal per-bucket counts make sure no padding is added.
- Uneven mixes, including empty buckets between loaded ones, check that the maximum is found and that padding lands only in unmodified slots.

The latency of each vector depends on the gap between the fullest and emptiest bucket, so the done timing separates a correct padding loop from one that stalls or takes too many steps. Two further directed tests cover a start raised while busy and a replayed seed, which must give a repeatable mask.

// File: rtl/ore_pkg.sv
package ore_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_PAD   = 2'd2,
    ST_DONE  = 2'd3
  } ore_state_e;

endpackage

// File: rtl/ore_lfsr.sv
module ore_lfsr #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    TAPS = 16'hB400,
  parameter logic [W-1:0]    INIT = 16'h0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] state_q, state_d;
  logic         state_en;

  always_comb begin
    state_en = load | step;
    state_d  = state_q;
    if (load) begin
      state_d = (load_val == '0) ? INIT : load_val;
    end else if (step) begin
      state_d = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= INIT;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/ore_popcount.sv
module ore_popcount #(
  parameter int W  = 4,
  parameter int CW = 3
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(bits[i]);
    end
  end

endmodule

// File: rtl/ore_max_reduce.sv
module ore_max_reduce #(
  parameter int N  = 5,
  parameter int CW = 3
) (
  input  logic [N-1:0][CW-1:0] vals,
  output logic [CW-1:0]        max_val
);

  always_comb begin
    max_val = '0;
    for (int i = 0; i < N; i++) begin
      if (vals[i] > max_val) begin
        max_val = vals[i];
      end
    end
  end

endmodule

// File: rtl/ore_pad_pick.sv
module ore_pad_pick #(
  parameter int SLOTS = 4,
  parameter int OW    = 2
) (
  input  logic [SLOTS-1:0] taken,
  input  logic [OW-1:0]    offset,
  output logic [SLOTS-1:0] pick
);

  logic found;

  // Circular scan from a random start: first free slot wins.
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      int idx;
      idx = (int'(offset) + k) % SLOTS;
      if (!found && !taken[idx]) begin
        pick[idx] = 1'b1;
        found     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ore_path_reenc_sel.sv
module ore_path_reenc_sel
  import ore_pkg::*;
#(
  parameter int                 DEPTH     = 4,
  parameter int                 SLOTS     = 4,
  parameter int                 LFSR_W    = 16,
  parameter logic [LFSR_W-1:0]  LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0]  LFSR_INIT = 16'h0001,
  localparam int                NB        = DEPTH + 1,
  localparam int                NS        = NB * SLOTS,
  localparam int                CW        = $clog2(SLOTS + 1),
  localparam int                OW        = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_value,
  input  logic              start,
  input  logic [NS-1:0]     mod_flags,
  output logic              busy,
  output logic              done,
  output logic [NS-1:0]     reenc_mask,
  output logic [CW-1:0]     target,
  output logic [NS-1:0]     ctr_strobe
);

  ore_state_e state_q, state_d;

  logic [NS-1:0]          flags_q;
  logic [NS-1:0]          mask_q, mask_d;
  logic [NS-1:0]          pad_bits;
  logic [CW-1:0]          target_q, target_d;
  logic [CW-1:0]          max_cnt;
  logic [NB-1:0][CW-1:0]  mod_cnt;
  logic [NB-1:0][CW-1:0]  sel_cnt;
  logic [NB-1:0][OW-1:0]  offset;
  logic [NB-1:0]          need;
  logic [LFSR_W-1:0]      lfsr_q;
  logic                   accept;
  logic                   lfsr_step;
  logic                   flags_en;
  logic                   mask_en;
  logic                   target_en;
  logic                   state_en;

  // Random source
  ore_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_TAPS),
    .INIT (LFSR_INIT)
  ) i_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (seed_load),
    .load_val (seed_value),
    .step     (lfsr_step),
    .state    (lfsr_q)
  );

  // Per-bucket scan offsets: fold a bucket-specific rotation of the LFSR
  always_comb begin
    offset = '0;
    for (int b = 0; b < NB; b++) begin
      for (int j = 0; j < LFSR_W; j++) begin
        offset[b][j % OW] = offset[b][j % OW] ^ lfsr_q[(j + b) % LFSR_W];
      end
    end
  end

  // Per-bucket counting and padding
  for (genvar b = 0; b < NB; b++) begin : gen_bucket
    logic [SLOTS-1:0] pick_b;

    ore_popcount #(.W(SLOTS), .CW(CW)) i_mod_cnt (
      .bits (flags_q[b*SLOTS +: SLOTS]),
      .cnt  (mod_cnt[b])
    );

    ore_popcount #(.W(SLOTS), .CW(CW)) i_sel_cnt (
      .bits (mask_q[b*SLOTS +: SLOTS]),
      .cnt  (sel_cnt[b])
    );

    ore_pad_pick #(.SLOTS(SLOTS), .OW(OW)) i_pick (
      .taken  (mask_q[b*SLOTS +: SLOTS]),
      .offset (offset[b]),
      .pick   (pick_b)
    );

    assign need[b] = (sel_cnt[b] < target_q);
    assign pad_bits[b*SLOTS +: SLOTS] = need[b] ? pick_b : '0;
  end

  ore_max_reduce #(.N(NB), .CW(CW)) i_max (
    .vals    (mod_cnt),
    .max_val (max_cnt)
  );

  // Next-state logic
  always_comb begin
    accept    = (state_q == ST_IDLE) && start;
    state_d   = state_q;
    mask_d    = mask_q;
    target_d  = target_q;
    flags_en  = 1'b0;
    mask_en   = 1'b0;
    target_en = 1'b0;
    lfsr_step = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          flags_en = 1'b1;
          mask_en  = 1'b1;
          mask_d   = mod_flags;
          state_d  = ST_COUNT;
        end
      end
      ST_COUNT: begin
        target_en = 1'b1;
        target_d  = max_cnt;
        state_d   = ST_PAD;
      end
      ST_PAD: begin
        if (need == '0) begin
          state_d = ST_DONE;
        end else begin
          mask_en   = 1'b1;
          mask_d    = mask_q | pad_bits;
          lfsr_step = 1'b1;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
    state_en = (state_d != state_q);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= mod_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
    end else if (target_en) begin
      target_q <= target_d;
    end
  end

  // Outputs
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign reenc_mask = mask_q;
  assign target     = target_q;
  assign ctr_strobe = done ? mask_q : '0;

endmodule

// File: rtl/ore_path_reenc_sel_chk.sv
module ore_path_reenc_sel_chk #(
  parameter int NB    = 5,
  parameter int SLOTS = 4,
  parameter int CW    = 3,
  localparam int NS   = NB * SLOTS
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [NS-1:0] mask,
  input logic [CW-1:0] target,
  input logic [NS-1:0] flags_q,
  input logic [NS-1:0] strobe
);

  AST_MOD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((mask & flags_q) == flags_q)) else $error("modified slot dropped"); // R2

  AST_NO_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (flags_q == '0)) |-> ((mask == '0) && (target == '0))) else $error("empty path wrote"); // R4

  AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (strobe == '0)) else $error("strobe outside done"); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R6

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy) else $error("done without busy"); // R6

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy) else $error("busy after done"); // R6

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(flags_q)) else $error("flags changed while busy"); // R7

  for (genvar b = 0; b < NB; b++) begin : gen_lvl
    AST_BUCKET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($countones(mask[b*SLOTS +: SLOTS]) == int'(target))) else $error("bucket count off"); // R3
  end

endmodule

bind ore_path_reenc_sel ore_path_reenc_sel_chk #(
  .NB    (NB),
  .SLOTS (SLOTS),
  .CW    (CW)
) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .mask    (reenc_mask),
  .target  (target),
  .flags_q (flags_q),
  .strobe  (ctr_strobe)
);

// File: tb/test_ore_path_reenc_sel.sv
`timescale 1ns/1ps
module test_ore_path_reenc_sel;

  localparam int DEPTH  = 4;
  localparam int SLOTS  = 4;
  localparam int LFSR_W = 16;
  localparam int NB     = DEPTH + 1;
  localparam int NS     = NB * SLOTS;
  localparam int CW     = $clog2(SLOTS + 1);
  localparam int NVEC   = 8;

  localparam logic [NS-1:0] VEC_FLAGS [NVEC] = '{
    20'h00000, 20'h00001, 20'hF0000, 20'h12481,
    20'h30700, 20'hFFFFF, 20'h0A050, 20'h8C3E1
  };
  localparam int VEC_TGT [NVEC] = '{0, 1, 4, 1, 3, 4, 2, 3};

  logic              clk;
  logic              rst_n;
  logic              seed_load;
  logic [LFSR_W-1:0] seed_value;
  logic              start;
  logic [NS-1:0]     mod_flags;
  logic              busy;
  logic              done;
  logic [NS-1:0]     reenc_mask;
  logic [CW-1:0]     target;
  logic [NS-1:0]     ctr_strobe;

  int n_chk;
  int n_fail;

  ore_path_reenc_sel #(.DEPTH(DEPTH), .SLOTS(SLOTS), .LFSR_W(LFSR_W)) i_ore_path_reenc_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (seed_load),
    .seed_value (seed_value),
    .start      (start),
    .mod_flags  (mod_flags),
    .busy       (busy),
    .done       (done),
    .reenc_mask (reenc_mask),
    .target     (target),
    .ctr_strobe (ctr_strobe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bcnt(input logic [NS-1:0] v, input int b);
    int c;
    c = 0;
    for (int i = 0; i < SLOTS; i++) c += int'(v[b*SLOTS + i]);
    return c;
  endfunction

  function automatic int min_cnt(input logic [NS-1:0] v);
    int m;
    m = SLOTS;
    for (int b = 0; b < NB; b++) if (bcnt(v, b) < m) m = bcnt(v, b);
    return m;
  endfunction

  // Launch an access; returns the mask, target and the edges from accept to done
  task automatic run_access(input logic [NS-1:0] f, output logic [NS-1:0] m,
                            output int t, output int edges, output bit busy_ok,
                            output bit strobe_ok);
    @(negedge clk);
    mod_flags = f;
    start     = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start     = 1'b0;
    mod_flags = '0;
    busy_ok   = busy;
    edges     = 0;
    while (!done && edges < 64) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (!done && !busy) busy_ok = 1'b0;
    end
    m         = reenc_mask;
    t         = int'(target);
    strobe_ok = (ctr_strobe == reenc_mask);
  endtask

  task automatic seed(input logic [LFSR_W-1:0] s);
    @(negedge clk);
    seed_load  = 1'b1;
    seed_value = s;
    @(negedge clk);
    seed_load  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NS-1:0] m, m2;
    int t, e, p;
    bit bok, sok;
    n_chk      = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    seed_load  = 1'b0;
    seed_value = '0;
    start      = 1'b0;
    mod_flags  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(busy == 1'b0, "R9", "busy", busy, 0);
    chk(done == 1'b0, "R9", "done", done, 0);
    chk(reenc_mask == '0, "R9", "mask", reenc_mask, 0);
    chk(target == '0, "R9", "target", target, 0);
    chk(ctr_strobe == '0, "R9", "strobe", ctr_strobe, 0);
    rst_n = 1'b1;
    seed(16'hACE1);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      run_access(VEC_FLAGS[v], m, t, e, bok, sok);
      p = VEC_TGT[v] - min_cnt(VEC_FLAGS[v]);
      chk(t == VEC_TGT[v], "R1", "target", t, VEC_TGT[v]);
      chk((m & VEC_FLAGS[v]) == VEC_FLAGS[v], "R2", "modified kept", m, VEC_FLAGS[v]);
      for (int b = 0; b < NB; b++)
        chk(bcnt(m, b) == VEC_TGT[v], "R3", "bucket count", bcnt(m, b), VEC_TGT[v]);
      if (VEC_FLAGS[v] == '0)
        chk(m == '0 && t == 0, "R4", "empty path mask", m, 0);
      chk(sok, "R5", "strobe at done", ctr_strobe, m);
      chk(e == p + 2, "R6", "done latency", e, p + 2);
      chk(bok, "R6", "busy while working", 0, 1);
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R6", "done single pulse", done, 0);
      chk(busy == 1'b0, "R6", "busy after done", busy, 0);
      chk(ctr_strobe == '0, "R5", "strobe after done", ctr_strobe, 0);
    end

    // R7: start while busy is ignored
    @(negedge clk);
    mod_flags = 20'h00001;
    start     = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mod_flags = 20'hFFFFF;
    start     = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start     = 1'b0;
    mod_flags = '0;
    e = 1;
    while (!done && e < 64) begin
      @(posedge clk);
      e++;
      @(negedge clk);
    end
    chk(e == 3, "R7", "latency of first access", e, 3);
    chk(int'(target) == 1, "R7", "target from first flags", target, 1);
    chk(reenc_mask[0] == 1'b1, "R7", "first flags kept", reenc_mask, 1);
    for (int b = 0; b < NB; b++)
      chk(bcnt(reenc_mask, b) == 1, "R7", "bucket count", bcnt(reenc_mask, b), 1);
    t = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (done) t++;
    end
    chk(t == 0, "R7", "no extra done", t, 0);
    chk(busy == 1'b0, "R7", "idle after ignored start", busy, 0);

    // R8: reproducible padding with a replayed seed
    seed(16'h5A17);
    run_access(20'h00001, m, t, e, bok, sok);
    seed(16'h5A17);
    run_access(20'h00001, m2, t, e, bok, sok);
    chk(m2 == m, "R8", "replayed seed mask", m2, m);
    seed(16'h0000);
    run_access(20'h0A050, m, t, e, bok, sok);
    seed(16'h0000);
    run_access(20'h0A050, m2, t, e, bok, sok);
    chk(m2 == m, "R8", "zero seed replay mask", m2, m);
    chk(t == 2, "R1", "target after zero seed", t, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule